// File: doc/BRIEF.md
# PCI Configuration Status Register

This block holds the 16-bit status word of a PCI function's configuration header. Bus-side logic reports error and termination events as single-cycle pulses; the block folds them into sticky flags that stay set until software clears them by writing a one to the flag's position. The block also reports a fixed device-select timing code of "medium" and a read-only flag saying whether an extended capability list exists. Every other bit reads as zero.

The configuration access port is a plain register port with no back-pressure: a write strobe with byte enables and data is consumed in the cycle it is presented, and read data is returned combinationally while the read strobe is high. Events are sampled on every rising clock edge. If an event and a clearing write hit the same flag on the same edge, the event wins.

Top module: `pcists_top`

## Requirements
- R1: A synchronous active-high reset clears all sticky flags; after reset the register reads 0x0200 with bit 4 added when `HAS_CAP_LIST` is 1 (0x0210 by default).
- R2: Bit 15 sets on a detected data parity error pulse whatever the value of the parity response enable.
- R3: Bit 14 sets on a pulse saying this agent drove the system error signal.
- R4: Bit 13 sets on a master-abort pulse, except when the special-cycle flag is high in the same cycle.
- R5: Bit 12 sets on a target-abort pulse received as master.
- R6: Bit 8 sets only when the parity-error-signal pulse, the bus-master flag and the parity response enable are all high in the same cycle.
- R7: A write with byte enable bit 1 high clears each sticky flag (bits 15, 14, 13, 12, 8) whose data bit is one and leaves the others unchanged.
- R8: A write with byte enable bit 1 low clears nothing, whatever the data and byte enable bit 0.
- R9: When an event and a clearing write address the same flag in the same cycle, the flag is set afterwards.
- R10: Bits 10:9 always read 01, bit 4 reads `HAS_CAP_LIST`, bits 11, 7:5 and 3:0 read zero, and writes change none of them.
- R11: `cfg_rdata` equals the register value while `cfg_rd` is high and zero otherwise.
- R12: With no event and no clearing write, every flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ev_par_det | input | 1 | Data parity error detected |
| ev_serr_drv | input | 1 | This agent drove system error |
| ev_mabort | input | 1 | Own master transaction ended in master-abort |
| ev_special | input | 1 | Current transaction is a special cycle |
| ev_tabort | input | 1 | Own master transaction ended in target-abort |
| ev_perr_seen | input | 1 | Parity error signal driven or observed |
| is_master | input | 1 | This agent was master of the failing operation |
| par_resp_en | input | 1 | Parity error response enable from the command word |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 2 | Byte enables, bit 1 covers bits 15:8 |
| cfg_wdata | input | 16 | Write data, ones clear flags |
| cfg_rd | input | 1 | Read strobe |
| cfg_rdata | output | 16 | Read data |
| status_q | output | 16 | Current register value |

## Verification
Every flag change is due exactly one clock edge after the event or write that causes it, and `cfg_rdata` follows `cfg_rd` in the same cycle with no register in between. The bench drives inputs on the falling edge, advances a behavioural model at the rising edge from those same inputs, and compares `status_q` and `cfg_rdata` on the next falling edge, so each result is checked in the first cycle it is due. Collision, lane-masking and special-cycle cases are placed in single cycles so that a late or early update shows as a mismatch.

// File: rtl/pcists_pkg.sv
package pcists_pkg;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned LANE_W  = 8;
  localparam int unsigned LANES   = REG_W / LANE_W;

  localparam int unsigned POS_DPE = 15;
  localparam int unsigned POS_SSE = 14;
  localparam int unsigned POS_RMA = 13;
  localparam int unsigned POS_RTA = 12;
  localparam int unsigned POS_DPR = 8;
  localparam int unsigned POS_CAP = 4;
  localparam int unsigned POS_DSL = 9;

  localparam logic [1:0] DSEL_FAST   = 2'b00;
  localparam logic [1:0] DSEL_MEDIUM = 2'b01;
  localparam logic [1:0] DSEL_SLOW   = 2'b10;

  localparam logic [REG_W-1:0] STICKY_MASK =
    (REG_W'(1) << POS_DPE) | (REG_W'(1) << POS_SSE) |
    (REG_W'(1) << POS_RMA) | (REG_W'(1) << POS_RTA) |
    (REG_W'(1) << POS_DPR);

  typedef struct packed {
    logic par_det;
    logic serr_drv;
    logic mabort;
    logic special;
    logic tabort;
    logic perr_seen;
    logic master;
    logic resp_en;
  } evt_t;
endpackage

// File: rtl/pcists_setlogic.sv
module pcists_setlogic
  import pcists_pkg::*;
(
  input  evt_t             evt,
  output logic [REG_W-1:0] set_vec
);
  always_comb begin
    set_vec          = '0;
    set_vec[POS_DPE] = evt.par_det;
    set_vec[POS_SSE] = evt.serr_drv;
    set_vec[POS_RMA] = evt.mabort & ~evt.special;
    set_vec[POS_RTA] = evt.tabort;
    set_vec[POS_DPR] = evt.perr_seen & evt.master & evt.resp_en;
  end
endmodule

// File: rtl/pcists_sticky.sv
module pcists_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/pcists_readmux.sv
module pcists_readmux
  import pcists_pkg::*;
#(
  parameter bit HAS_CAP_LIST = 1'b1
) (
  input  logic [REG_W-1:0] flags,
  input  logic             rd,
  output logic [REG_W-1:0] value,
  output logic [REG_W-1:0] rdata
);
  always_comb begin
    value                   = flags & STICKY_MASK;
    value[POS_DSL+1:POS_DSL] = DSEL_MEDIUM;
    value[POS_CAP]          = HAS_CAP_LIST;
  end
  assign rdata = rd ? value : '0;
endmodule

// File: rtl/pcists_top.sv
module pcists_top
  import pcists_pkg::*;
#(
  parameter bit HAS_CAP_LIST = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ev_par_det,
  input  logic        ev_serr_drv,
  input  logic        ev_mabort,
  input  logic        ev_special,
  input  logic        ev_tabort,
  input  logic        ev_perr_seen,
  input  logic        is_master,
  input  logic        par_resp_en,
  input  logic        cfg_wr,
  input  logic [1:0]  cfg_be,
  input  logic [15:0] cfg_wdata,
  input  logic        cfg_rd,
  output logic [15:0] cfg_rdata,
  output logic [15:0] status_q
);
  evt_t             evt;
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] flags;
  logic             unused_bits;

  assign evt = '{par_det:   ev_par_det,
                 serr_drv:  ev_serr_drv,
                 mabort:    ev_mabort,
                 special:   ev_special,
                 tabort:    ev_tabort,
                 perr_seen: ev_perr_seen,
                 master:    is_master,
                 resp_en:   par_resp_en};

  pcists_setlogic u_set (.evt(evt), .set_vec(set_vec));

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    assign clr_vec[i] = cfg_wr & cfg_be[i / LANE_W] & cfg_wdata[i];
    if (STICKY_MASK[i]) begin : g_flag
      pcists_sticky u_flag (
        .clk  (clk),
        .rst  (rst),
        .set_i(set_vec[i]),
        .clr_i(clr_vec[i]),
        .q    (flags[i])
      );
    end else begin : g_fixed
      assign flags[i] = 1'b0;
    end
  end

  assign unused_bits = ^{clr_vec & ~STICKY_MASK, set_vec & ~STICKY_MASK};

  pcists_readmux #(.HAS_CAP_LIST(HAS_CAP_LIST)) u_rd (
    .flags(flags),
    .rd   (cfg_rd),
    .value(status_q),
    .rdata(cfg_rdata)
  );
endmodule

// File: rtl/pcists_chk.sv
module pcists_chk (
  input logic        clk,
  input logic        rst,
  input logic        ev_par_det,
  input logic        ev_serr_drv,
  input logic        ev_mabort,
  input logic        ev_special,
  input logic        ev_tabort,
  input logic        ev_perr_seen,
  input logic        is_master,
  input logic        par_resp_en,
  input logic        cfg_wr,
  input logic [1:0]  cfg_be,
  input logic [15:0] cfg_wdata,
  input logic        cfg_rd,
  input logic [15:0] cfg_rdata,
  input logic [15:0] status_q
);
  logic any_evt;
  assign any_evt = ev_par_det | ev_serr_drv | ev_mabort | ev_tabort | ev_perr_seen;

  p_reset_r1: assert property (@(posedge clk) rst |=> (status_q[15:12] == 4'b0 && !status_q[8]));
  p_dpe_set_r2: assert property (@(posedge clk) disable iff (rst) ev_par_det |=> status_q[15]);
  p_sse_set_r3: assert property (@(posedge clk) disable iff (rst) ev_serr_drv |=> status_q[14]);
  p_rma_special_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q[13]) |-> $past(ev_mabort && !ev_special));
  p_rta_set_r5: assert property (@(posedge clk) disable iff (rst) ev_tabort |=> status_q[12]);
  p_dpr_cond_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q[8]) |-> $past(ev_perr_seen && is_master && par_resp_en));
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_be[1] && cfg_wdata[15] && !ev_par_det) |=> !status_q[15]);
  p_lane_off_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !cfg_be[1] && !any_evt) |=> $stable(status_q));
  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (ev_serr_drv && cfg_wr && cfg_be[1] && cfg_wdata[14]) |=> status_q[14]);
  p_fixed_r10: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (status_q[10:9] == 2'b01 && status_q[11] == 1'b0 && status_q[3:0] == 4'b0));
  p_rdata_r11: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata == (cfg_rd ? status_q : 16'h0));
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!any_evt && !cfg_wr) |=> $stable(status_q));
endmodule

bind pcists_top pcists_chk u_chk (
  .clk(clk), .rst(rst), .ev_par_det(ev_par_det), .ev_serr_drv(ev_serr_drv),
  .ev_mabort(ev_mabort), .ev_special(ev_special), .ev_tabort(ev_tabort),
  .ev_perr_seen(ev_perr_seen), .is_master(is_master), .par_resp_en(par_resp_en),
  .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd),
  .cfg_rdata(cfg_rdata), .status_q(status_q)
);

// File: tb/sim_pcists_top.sv
`timescale 1ns/1ps
module sim_pcists_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_par_det = 0, ev_serr_drv = 0, ev_mabort = 0, ev_special = 0;
  logic        ev_tabort = 0, ev_perr_seen = 0, is_master = 0, par_resp_en = 0;
  logic        cfg_wr = 0, cfg_rd = 0;
  logic [1:0]  cfg_be = 2'b00;
  logic [15:0] cfg_wdata = 16'h0;
  logic [15:0] cfg_rdata, status_q;

  logic [15:0] model = 16'h0;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  pcists_top u0 (.*);

  function automatic logic [15:0] expected_value();
    return model | 16'h0200 | 16'h0010;
  endfunction

  task automatic compare(input string tag);
    logic [15:0] ev;
    ev = expected_value();
    checks++;
    if (status_q !== ev) begin
      fails++;
      $display("FAIL %s status_q actual=%h expected=%h", tag, status_q, ev);
    end
    checks++;
    if (cfg_rdata !== (cfg_rd ? ev : 16'h0)) begin
      fails++;
      $display("FAIL %s cfg_rdata actual=%h expected=%h", tag, cfg_rdata,
               cfg_rd ? ev : 16'h0);
    end
  endtask

  // Behavioural reference: one rising edge with the inputs now applied.
  task automatic model_edge();
    logic [15:0] s, c;
    if (rst) begin model = 16'h0; return; end
    s = 16'h0;
    if (ev_par_det) s = s | 16'h8000;
    if (ev_serr_drv) s = s | 16'h4000;
    if (ev_mabort && !ev_special) s = s | 16'h2000;
    if (ev_tabort) s = s | 16'h1000;
    if (ev_perr_seen && is_master && par_resp_en) s = s | 16'h0100;
    c = (cfg_wr && cfg_be[1]) ? (cfg_wdata & 16'hF100) : 16'h0;
    model = (model & ~c) | s;
  endtask

  task automatic idle_inputs();
    {ev_par_det, ev_serr_drv, ev_mabort, ev_special} = '0;
    {ev_tabort, ev_perr_seen, is_master, par_resp_en} = '0;
    cfg_wr = 0; cfg_be = 2'b00; cfg_wdata = 16'h0;
  endtask

  // Inputs are set by the caller after a falling edge; this advances one cycle.
  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
    idle_inputs();
  endtask

  task automatic wr(input logic [1:0] be, input logic [15:0] d);
    cfg_wr = 1; cfg_be = be; cfg_wdata = d;
  endtask

  initial begin
    @(negedge clk);
    rst = 1;
    step("R1 reset");
    rst = 0;
    cfg_rd = 1;
    step("R1 after reset");
    if (status_q !== 16'h0210) begin
      fails++; $display("FAIL R1 reset value actual=%h expected=0210", status_q);
    end
    checks++;

    ev_par_det = 1; par_resp_en = 0; step("R2 parity detect, response off");
    ev_serr_drv = 1; step("R3 system error");
    ev_mabort = 1; ev_special = 1; step("R4 special cycle excluded");
    ev_mabort = 1; step("R4 master abort");
    ev_tabort = 1; step("R5 target abort");

    ev_perr_seen = 1; is_master = 1; par_resp_en = 0; step("R6 enable low");
    ev_perr_seen = 1; is_master = 0; par_resp_en = 1; step("R6 not master");
    ev_perr_seen = 0; is_master = 1; par_resp_en = 1; step("R6 no perr");
    ev_perr_seen = 1; is_master = 1; par_resp_en = 1; step("R6 all three");

    cfg_rd = 0; step("R11 read strobe low");
    cfg_rd = 1;
    step("R12 hold idle");
    step("R12 hold idle again");

    wr(2'b01, 16'hFFFF); step("R8 low lane only");
    wr(2'b00, 16'hFFFF); step("R8 no lanes");
    wr(2'b11, 16'h8000); step("R7 clear bit 15 only");
    wr(2'b10, 16'h0EFF); step("R10 writes to fixed bits ignored");

    ev_serr_drv = 1; wr(2'b10, 16'h4000); step("R9 set beats clear");
    ev_par_det = 1; wr(2'b10, 16'hC000); step("R9 bit 15 set wins, bit 14 clears");
    wr(2'b10, 16'h3100); step("R7 clear 13 12 8");
    wr(2'b11, 16'hFFFF); step("R7 clear all");

    ev_tabort = 1; ev_mabort = 1; step("R5 R4 together");
    rst = 1; step("R1 reset again");
    rst = 0; step("R1 released");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule